// File: doc/BRIEF.md
# Microwire EEPROM host controller

This block drives a serial EEPROM that speaks the three-wire Microwire protocol. Each transaction is launched from a parallel command port carrying a 2-bit opcode, an address, write data and a start strobe. The controller raises chip select and generates the serial clock by dividing the system clock. It then sends a leading 1 followed by the opcode and the address, plus a data word when the command writes. For a read it captures the returned word. One system-clock pulse on the done output reports the end of every transaction.

Commands that program the array are write, erase, write-all and erase-all. After one of these, the controller drops chip select for at least one serial clock period and then selects the device again. It keeps sampling the data-out line until the device reports ready, or until a poll budget runs out. When the release option is built in, the controller clocks in a single 1 on data-in after ready. This makes the device float its data-out line, so data-in and data-out may share one wire. A port bit selects between 16-bit and 8-bit word organization. The 8-bit organization adds one address bit to the frame.

Top module: `mw_eeprom_host`

## Requirements
- R1: Each command frame starts with a 1 bit, then the 2-bit opcode, then the address, all MSB first. In 16-bit mode the address is ADDR_W bits and the frame is 11 bits at the default ADDR_W=8. In 8-bit mode the address is ADDR_W+1 bits and the frame is 12 bits. Opcode 10 reads, 01 writes and 11 erases. Opcode 00 takes its sub-command from the top two address bits: 01 is write-all, 10 is erase-all, and 11 or 00 is a plain command with no poll.
- R2: Data-in changes only while the serial clock is low, so it holds steady across every rising edge. The device samples data-in on that rising edge.
- R3: Write and write-all send the data word MSB first directly after the address. The word is 16 bits in 16-bit mode and the low 8 bits of cmd_wdata in 8-bit mode.
- R4: On a read, the controller ignores the bit sampled at the first rising edge after the frame (the device's leading 0). It then captures 16 or 8 bits MSB first at the next rising edges. The result appears zero-extended on cmd_rdata.
- R5: After a programming command, chip select stays low for at least 2*SK_HALF system cycles before it rises again for the status poll.
- R6: During the poll, data-out sampled low at a rising edge means busy and polling continues. Data-out sampled high ends the transaction with cmd_err low.
- R7: With RELEASE_EN=1, after ready the controller holds data-in at 1 across one rising serial clock edge while chip select is still high. It then drops chip select. On a timeout no such 1 is sent.
- R8: If POLL_LIMIT consecutive poll samples read busy, the transaction ends with cmd_err high. At POLL_LIMIT-1 busy samples it still ends without error.
- R9: A start strobe that arrives while cmd_busy is high is ignored: no second frame is sent and the running command completes unchanged.
- R10: During and after reset, chip select, serial clock, data-in, cmd_busy, cmd_done, cmd_err and cmd_rdata are all low.
- R11: The serial clock period is 2*SK_HALF system cycles. cmd_done is a one-cycle pulse, and cmd_busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Launches a command when idle |
| cmd_org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cmd_op | input | 2 | Command opcode |
| cmd_addr | input | ADDR_W+1 | Word address; only the low ADDR_W bits are used in 16-bit mode |
| cmd_wdata | input | 16 | Data for write and write-all |
| cmd_rdata | output | 16 | Word captured by the last read |
| cmd_busy | output | 1 | A command or poll is in progress |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| cmd_err | output | 1 | Last command ended on a poll timeout |
| eep_cs | output | 1 | Chip select to the device |
| eep_sk | output | 1 | Serial clock to the device |
| eep_di | output | 1 | Serial data to the device |
| eep_dout | input | 1 | Serial data from the device |

## Verification
The results of a command become visible at different times. The frame bits appear on the wire at serial clock rising edges. cmd_rdata and cmd_err are settled in the same system cycle that cmd_done pulses, which follows the falling serial clock edge after the final rising edge of the frame, the data or the poll. The bench models the device on the serial clock edges. It drives data-out 1 ns after each rising edge, so the controller samples the value presented after the previous edge. The bench waits on the falling system clock edge for the done pulse and reads the command results in that cycle. It checks the pulse width one cycle later. The chip-select gap and the serial clock period are timed in the bench from edge timestamps.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_GAP,
      ST_POLL,
      ST_REL_SET,
      ST_REL_CLK,
      ST_TAIL
   } mw_state_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] SUB_WRALL = 2'b01;
   localparam logic [1:0] SUB_ERALL = 2'b10;

endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
   parameter int SK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sk,
   output logic rise_ev,
   output logic fall_ev
);

   generate
      if (SK_HALF == 1) begin : g_fast
         assign rise_ev = run && !sk;
         assign fall_ev = run && sk;
      end else begin : g_div
         localparam int CW = $clog2(SK_HALF);
         logic [CW-1:0] cnt;
         logic          tick;

         assign tick = run && (cnt == CW'(SK_HALF - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign rise_ev = tick && !sk;
         assign fall_ev = tick && sk;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sk <= 1'b0;
      else if (!run)
         sk <= 1'b0;
      else if (rise_ev)
         sk <= 1'b1;
      else if (fall_ev)
         sk <= 1'b0;
   end

endmodule

// File: rtl/mw_frame.sv
module mw_frame
   import mw_host_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SR_W   = ADDR_W + 20,
   parameter int CNT_W  = 6
) (
   input  logic              org16,
   input  logic [1:0]        op,
   input  logic [ADDR_W:0]   addr,
   input  logic [15:0]       wdata,
   output logic [SR_W-1:0]   bits,
   output logic [CNT_W-1:0]  n_rise,
   output logic [CNT_W-1:0]  n_skip,
   output logic              is_read,
   output logic              is_prog
);

   logic [1:0] sub;
   logic       has_data;
   int         nf;
   int         nw;

   always_comb begin
      sub      = org16 ? addr[ADDR_W-1 -: 2] : addr[ADDR_W -: 2];
      has_data = (op == OP_WRITE) || (op == OP_EXT && sub == SUB_WRALL);
      is_read  = (op == OP_READ);
      is_prog  = (op == OP_WRITE) || (op == OP_ERASE) ||
                 (op == OP_EXT && (sub == SUB_WRALL || sub == SUB_ERALL));
      if (org16) begin
         bits = {1'b1, op, addr[ADDR_W-1:0], (has_data ? wdata : 16'h0000), 1'b0};
         nf   = ADDR_W + 3;
         nw   = 16;
      end else begin
         bits = {1'b1, op, addr, (has_data ? wdata[7:0] : 8'h00), 8'h00};
         nf   = ADDR_W + 4;
         nw   = 8;
      end
      n_skip = CNT_W'(nf + 1);
      if (is_read)
         n_rise = CNT_W'(nf + nw + 1);
      else if (has_data)
         n_rise = CNT_W'(nf + nw);
      else
         n_rise = CNT_W'(nf);
   end

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
   import mw_host_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int SK_HALF    = 2,
   parameter int POLL_LIMIT = 32,
   parameter int RELEASE_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_org16,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W:0]   cmd_addr,
   input  logic [15:0]       cmd_wdata,
   output logic [15:0]       cmd_rdata,
   output logic              cmd_busy,
   output logic              cmd_done,
   output logic              cmd_err,
   output logic              eep_cs,
   output logic              eep_sk,
   output logic              eep_di,
   input  logic              eep_dout
);

   localparam int SR_W  = ADDR_W + 20;
   localparam int CNT_W = $clog2(ADDR_W + 24) + 1;
   localparam int PCW   = $clog2(POLL_LIMIT + 1);

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 2..12");
      end
      if (SK_HALF < 1) begin : g_bad_half
         $error("SK_HALF must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 1");
      end
      if (RELEASE_EN != 0 && RELEASE_EN != 1) begin : g_bad_rel
         $error("RELEASE_EN must be 0 or 1");
      end
   endgenerate

   mw_state_e         state;
   mw_state_e         ready_st;
   logic [SR_W-1:0]   sreg;
   logic [CNT_W-1:0]  total;
   logic [CNT_W-1:0]  skip;
   logic [CNT_W-1:0]  rises;
   logic [PCW-1:0]    pcnt;
   logic              rd_mode;
   logic              prog;
   logic              tmo;
   logic              run;
   logic              rise_ev;
   logic              fall_ev;
   logic              in_poll;

   logic [SR_W-1:0]   f_bits;
   logic [CNT_W-1:0]  f_rise;
   logic [CNT_W-1:0]  f_skip;
   logic              f_read;
   logic              f_prog;

   mw_sk_gen #(.SK_HALF(SK_HALF)) u_skgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .sk      (eep_sk),
      .rise_ev (rise_ev),
      .fall_ev (fall_ev)
   );

   mw_frame #(.ADDR_W(ADDR_W), .SR_W(SR_W), .CNT_W(CNT_W)) u_frame (
      .org16   (cmd_org16),
      .op      (cmd_op),
      .addr    (cmd_addr),
      .wdata   (cmd_wdata),
      .bits    (f_bits),
      .n_rise  (f_rise),
      .n_skip  (f_skip),
      .is_read (f_read),
      .is_prog (f_prog)
   );

   generate
      if (RELEASE_EN != 0) begin : g_release
         assign ready_st = ST_REL_SET;
      end else begin : g_plain
         assign ready_st = ST_TAIL;
      end
   endgenerate

   assign cmd_busy = (state != ST_IDLE);
   assign in_poll  = (state == ST_POLL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sreg      <= '0;
         total     <= '0;
         skip      <= '0;
         rises     <= '0;
         pcnt      <= '0;
         rd_mode   <= 1'b0;
         prog      <= 1'b0;
         tmo       <= 1'b0;
         run       <= 1'b0;
         eep_cs    <= 1'b0;
         eep_di    <= 1'b0;
         cmd_done  <= 1'b0;
         cmd_err   <= 1'b0;
         cmd_rdata <= '0;
      end else begin
         cmd_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cmd_start) begin
                  sreg      <= f_bits;
                  total     <= f_rise;
                  skip      <= f_skip;
                  rd_mode   <= f_read;
                  prog      <= f_prog;
                  rises     <= '0;
                  tmo       <= 1'b0;
                  cmd_err   <= 1'b0;
                  cmd_rdata <= '0;
                  eep_cs    <= 1'b1;
                  eep_di    <= f_bits[SR_W-1];
                  run       <= 1'b1;
                  state     <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (rise_ev) begin
                  rises <= rises + 1'b1;
                  if (rd_mode && rises >= skip)
                     cmd_rdata <= {cmd_rdata[14:0], eep_dout};
               end else if (fall_ev) begin
                  if (rises == total) begin
                     eep_cs <= 1'b0;
                     eep_di <= 1'b0;
                     if (prog) begin
                        state <= ST_GAP;
                     end else begin
                        run      <= 1'b0;
                        cmd_done <= 1'b1;
                        state    <= ST_IDLE;
                     end
                  end else begin
                     sreg   <= sreg << 1;
                     eep_di <= sreg[SR_W-2];
                  end
               end
            end
            ST_GAP: begin
               if (fall_ev) begin
                  eep_cs <= 1'b1;
                  pcnt   <= '0;
                  state  <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (rise_ev) begin
                  if (eep_dout) begin
                     state <= ready_st;
                  end else if (pcnt == PCW'(POLL_LIMIT - 1)) begin
                     tmo   <= 1'b1;
                     state <= ST_TAIL;
                  end else begin
                     pcnt <= pcnt + 1'b1;
                  end
               end
            end
            ST_REL_SET: begin
               if (fall_ev) begin
                  eep_di <= 1'b1;
                  state  <= ST_REL_CLK;
               end
            end
            ST_REL_CLK: begin
               if (rise_ev)
                  state <= ST_TAIL;
            end
            ST_TAIL: begin
               if (fall_ev) begin
                  eep_cs   <= 1'b0;
                  eep_di   <= 1'b0;
                  run      <= 1'b0;
                  cmd_err  <= tmo;
                  cmd_done <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
   parameter int SK_HALF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_start,
   input logic cmd_busy,
   input logic cmd_done,
   input logic cmd_err,
   input logic eep_cs,
   input logic eep_sk,
   input logic eep_di,
   input logic in_poll
);

   logic [15:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_cnt <= '0;
      else if (eep_cs)
         gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF)
         gap_cnt <= gap_cnt + 1'b1;
   end

   assert_di_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eep_sk) |-> $stable(eep_di));

   assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eep_cs) && in_poll) |-> (gap_cnt >= 16'(2 * SK_HALF)));

   assert_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> cmd_done);

   assert_cs_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eep_cs) && !in_poll) |-> ($past(cmd_start) && !$past(cmd_busy)));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_busy |-> (!eep_cs && !eep_sk && !eep_di));

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (!cmd_busy && $past(cmd_busy)));

endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.SK_HALF(SK_HALF)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_start (cmd_start),
   .cmd_busy  (cmd_busy),
   .cmd_done  (cmd_done),
   .cmd_err   (cmd_err),
   .eep_cs    (eep_cs),
   .eep_sk    (eep_sk),
   .eep_di    (eep_di),
   .in_poll   (in_poll)
);

// File: tb/mw_eeprom_host_bench.sv
`timescale 1ns/1ps
module mw_eeprom_host_bench;

   localparam int ADDR_W     = 8;
   localparam int SK_HALF    = 2;
   localparam int POLL_LIMIT = 32;
   localparam int NV         = 9;

   // fields: org16 | op | addr(9) | wdata(16) | busy polls(8) | expected err
   localparam logic [36:0] VEC [NV] = '{
      {1'b1, 2'b10, 9'h05A, 16'h0000, 8'd0,  1'b0},
      {1'b0, 2'b10, 9'h1C3, 16'h0000, 8'd0,  1'b0},
      {1'b1, 2'b01, 9'h0A7, 16'hBEEF, 8'd5,  1'b0},
      {1'b0, 2'b01, 9'h0F3, 16'h0096, 8'd0,  1'b0},
      {1'b1, 2'b11, 9'h012, 16'h0000, 8'd31, 1'b0},
      {1'b1, 2'b00, 9'h0C0, 16'h0000, 8'd0,  1'b0},
      {1'b0, 2'b00, 9'h100, 16'h0000, 8'd3,  1'b0},
      {1'b1, 2'b00, 9'h040, 16'h1234, 8'd2,  1'b0},
      {1'b1, 2'b01, 9'h033, 16'h5555, 8'd32, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_org16 = 1'b1;
   logic [1:0]  cmd_op = 2'b00;
   logic [8:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] cmd_rdata;
   logic        cmd_busy, cmd_done, cmd_err;
   logic        eep_cs, eep_sk, eep_di;
   logic        mdo = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   mw_eeprom_host #(.ADDR_W(ADDR_W), .SK_HALF(SK_HALF), .POLL_LIMIT(POLL_LIMIT), .RELEASE_EN(1))
   u_mw_eeprom_host (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_org16(cmd_org16),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
      .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di), .eep_dout(mdo)
   );

   // ---------------- device model ----------------
   logic [63:0] rx_bits = '0;
   logic [63:0] frm = '0;
   int  rx_cnt = 0;
   bit  polling = 0;
   int  busy_left = 0;
   int  busy_set = 0;
   bit  rel_seen = 0;
   int  m_n = 11, m_w = 16, m_aw = 8;
   bit  m_org16 = 1;
   realtime t_cs_fall = 0.0;
   real gap_cyc = -1.0;
   realtime t_last_rise = 0.0;
   int  per_bad = 0;
   int  per_seen = 0;
   int  cs_rises = 0;

   function automatic logic [15:0] mword(input bit org, input logic [8:0] a);
      if (org) return {~a[7:0], a[7:0] ^ 8'h3C};
      return {8'h00, a[7:0] ^ 8'h5A ^ {a[8], 7'b0}};
   endfunction

   function automatic bit is_prog_frame(input logic [63:0] f, input int n, input int aw);
      logic [1:0] op, sub;
      op  = 2'((f >> (n - 3)) & 64'd3);
      sub = 2'((f >> (aw - 2)) & 64'd3);
      return (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && (sub == 2'b01 || sub == 2'b10));
   endfunction

   always @(posedge eep_cs) begin
      cs_rises++;
      if (polling) begin
         gap_cyc = ($realtime - t_cs_fall) / 4.0;
         mdo = (busy_left == 0);
      end else begin
         rx_cnt = 0;
         rx_bits = '0;
         t_last_rise = 0.0;
      end
   end

   always @(negedge eep_cs) begin
      t_cs_fall = $realtime;
      if (polling) polling = 0;
      else if (is_prog_frame(frm, m_n, m_aw)) begin
         polling = 1;
         busy_left = busy_set;
      end
      mdo = 1'b0;
   end

   always @(posedge eep_sk) begin
      if (t_last_rise > 0.0) begin
         per_seen++;
         if (($realtime - t_last_rise) != 4.0 * 2 * SK_HALF) per_bad++;
      end
      t_last_rise = $realtime;
      if (eep_cs) begin
         if (polling) begin
            if (mdo && eep_di) rel_seen = 1;
            #1;
            if (busy_left > 0) busy_left--;
            mdo = (busy_left == 0);
         end else begin
            rx_bits = {rx_bits[62:0], eep_di};
            rx_cnt++;
            if (rx_cnt == m_n) frm = rx_bits;
            if (rx_cnt >= m_n && ((frm >> (m_n - 3)) & 64'd3) == 64'd2) begin
               int k;
               logic [15:0] w;
               k = rx_cnt - m_n;
               w = mword(m_org16, 9'(frm & ((64'd1 << m_aw) - 1)));
               #1;
               if (k == 0 || k > m_w) mdo = 1'b0;
               else mdo = w[m_w - k];
            end
         end
      end
   end

   // DI must not move while SK stays high (R2)
   logic sk_q = 1'b0, di_q = 1'b0;
   int   di_bad = 0;
   always @(negedge clk) begin
      if (sk_q && eep_sk && (eep_di !== di_q)) di_bad++;
      sk_q = eep_sk;
      di_q = eep_di;
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input bit org, input logic [1:0] op, input logic [8:0] addr,
                          input logic [15:0] wd, input int busy);
      m_org16 = org;
      m_n  = org ? ADDR_W + 3 : ADDR_W + 4;
      m_aw = org ? ADDR_W : ADDR_W + 1;
      m_w  = org ? 16 : 8;
      busy_set = busy;
      rel_seen = 0;
      gap_cyc = -1.0;
      cmd_org16 = org; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      int n;
      n = 0;
      while (n < 20000 && cmd_done !== 1'b1) begin
         @(negedge clk);
         n++;
      end
      ok = (cmd_done === 1'b1);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      bit ok;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {cmd_rdata, cmd_busy, cmd_done, cmd_err, eep_cs, eep_sk, eep_di}, '0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 idle after reset", {cmd_busy, eep_cs, eep_sk, eep_di}, '0);

      for (int i = 0; i < NV; i++) begin
         logic [36:0] v;
         bit org, experr, rd, hasd, pg;
         logic [1:0] op, sub;
         logic [8:0] addr;
         logic [15:0] wd;
         int n, aw, w, busy;
         logic [63:0] efrm, mask;
         v = VEC[i];
         org = v[36]; op = v[35:34]; addr = v[33:25]; wd = v[24:9]; busy = int'(v[8:1]); experr = v[0];
         n = org ? ADDR_W + 3 : ADDR_W + 4;
         aw = org ? ADDR_W : ADDR_W + 1;
         w = org ? 16 : 8;
         mask = (64'd1 << aw) - 1;
         sub = 2'((64'(addr) >> (aw - 2)) & 64'd3);
         rd = (op == 2'b10);
         hasd = (op == 2'b01) || (op == 2'b00 && sub == 2'b01);
         pg = (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && (sub == 2'b01 || sub == 2'b10));
         efrm = (64'd1 << (n - 1)) | (64'(op) << aw) | (64'(addr) & mask);
         run_cmd(org, op, addr, wd, busy);
         wait_done(ok);
         chk("R11 done seen", 64'(ok), 64'd1);
         chk("R1 frame bits", frm & ((64'd1 << n) - 1), efrm);
         chk("R1 rising edge count", 64'(rx_cnt), 64'(n + (rd ? w + 1 : (hasd ? w : 0))));
         if (hasd)
            chk("R3 data bits", rx_bits & ((64'd1 << w) - 1), 64'(wd) & ((64'd1 << w) - 1));
         chk("R4 read data", 64'(cmd_rdata), rd ? 64'(mword(org, addr)) : 64'd0);
         chk(experr ? "R8 timeout err" : "R6 ready err", 64'(cmd_err), 64'(experr));
         if (pg) begin
            chk("R5 cs gap ok", 64'(gap_cyc >= real'(2 * SK_HALF)), 64'd1);
            chk("R7 release bit", 64'(rel_seen), experr ? 64'd0 : 64'd1);
         end
         @(negedge clk);
         chk("R11 done pulse width", {cmd_done, cmd_busy}, 64'd0);
         repeat (4) @(negedge clk);
      end

      // R9: start while busy is ignored
      begin
         int rises_before;
         run_cmd(1'b1, 2'b10, 9'h011, 16'h0000, 0);
         repeat (8) @(negedge clk);
         chk("R9 busy mid-command", 64'(cmd_busy), 64'd1);
         cmd_op = 2'b01; cmd_addr = 9'h022; cmd_wdata = 16'hFFFF;
         cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
         wait_done(ok);
         rises_before = cs_rises;
         chk("R9 first frame kept", frm & ((64'd1 << 11) - 1), (64'd1 << 10) | (64'd2 << 8) | 64'h11);
         chk("R9 read result kept", 64'(cmd_rdata), 64'(mword(1'b1, 9'h011)));
         repeat (60) @(negedge clk);
         chk("R9 no second frame", 64'(cs_rises - rises_before), 64'd0);
      end

      chk("R2 di stable while sk high", 64'(di_bad), 64'd0);
      chk("R11 sk period", 64'(per_bad), 64'd0);
      chk("R11 sk periods observed", 64'(per_seen > 100), 64'd1);
      finish_run();
   end

endmodule